// File: doc/BRIEF.md
# Graphics Port Request Issue and Status Sequencer

This block is the bus-master side of a pipelined graphics port. An internal queue offers read and write requests. Each request carries a direction, a priority (high or low) and a full-width address. When the arbiter grants the bus and signals permission to start, the block raises its pipelined-request strobe and presents one request address per clock on the multiplexed address/data bus. When the queue runs dry, the grant is withdrawn, or the relevant tracking counter is full, it parks the strobe in the deasserted state for one cycle and then releases its output enable.

Once a request is issued, the arbiter steers data movement with a 3-bit status code. That code means something only while the active-low grant is asserted. The block decodes returned high- and low-priority read data and requests for high- and low-priority write data into one-cycle event pulses, and it keeps an outstanding-request count for each of the four categories. An active-low read-buffer-full flag, derived from the free space in the low-priority read buffer, holds off low-priority read returns only. Returns that arrive with nothing outstanding, reserved codes, and low-priority read returns that violate the flag all set sticky error bits.

Top module: `agp_req_seq`

## Requirements
- R1: While `rst_n` is sampled low, `pipe_oe`, `ad_oe` and `rbf_oe` are 0 and both error bits are cleared. On the first clock after reset is released, `rbf_oe` becomes 1.
- R2: While `gnt_n` is 1, `st_code` has no effect: `req_ready` stays 0, no request is issued, and `ret_evt` stays 0.
- R3: When `gnt_n`=0, `st_code`=3'b111 and `req_valid`=1 (the category is not full and the issue phase is not parking), `req_ready` is 1 in the same cycle. On the next clock, `pipe_n`=0, `ad_oe`=1 and `ad_out` carries that request's address. Exactly one request is presented per clock.
- R4: After the last issued request, `pipe_n` returns to 1 with `pipe_oe` still 1 and `ad_oe` 0 for exactly one cycle. On the following clock, `pipe_oe` drops to 0.
- R5: During grant, status codes 3'b000 (low-priority read return), 3'b001 (high-priority read return), 3'b010 (low-priority write data) and 3'b011 (high-priority write data) produce a one-cycle pulse on the next clock. The pulse appears on `ret_evt` bit 0, 1, 2 and 3 respectively.
- R6: Outstanding requests are counted per category, indexed as {`req_write`,`req_hipri`}. A category holding OUT_MAX outstanding requests makes `req_ready` 0 for further requests of that category.
- R7: A return whose category has zero outstanding requests sets the sticky `cnt_err` on the next clock. The count does not wrap, so OUT_MAX new requests of that category are still accepted afterwards.
- R8: `rbf_n` is 0 on the clock after `lo_free` < XFER_WORDS, and 1 on the clock after `lo_free` >= XFER_WORDS.
- R9: A high-priority read return (3'b001) while `rbf_n`=0 still pulses `ret_evt` bit 1 and does not set `proto_err`.
- R10: A low-priority read return (3'b000) while `rbf_n`=0 sets the sticky `proto_err`.
- R11: Reserved codes 3'b100, 3'b101 and 3'b110 during grant produce no event and no issue, and set the sticky `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Internal queue offers a request |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_hipri | input | 1 | 1 = high priority |
| req_addr | input | AD_W | Request address |
| gnt_n | input | 1 | Active-low bus grant |
| st_code | input | 3 | Arbiter status code |
| lo_free | input | BUF_W | Free entries in low-priority read buffer |
| pipe_n | output | 1 | Active-low pipelined-request strobe |
| pipe_oe | output | 1 | Output enable for pipe_n |
| ad_out | output | AD_W | Address presented on the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| rbf_n | output | 1 | Active-low read-buffer-full flag |
| rbf_oe | output | 1 | Output enable for rbf_n |
| ret_evt | output | 4 | One-cycle status event per category |
| cnt_err | output | 1 | Sticky return-without-request error |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench targets a status code presented without grant. A design that ignores the grant would issue requests or report phantom returns. It checks the one-cycle park after a burst, where a wrong design would either float the strobe while it is still low or keep driving it. A high-priority read return is sent while the buffer-full flag is low, so a design that blocks both priorities would raise a false error. A return is sent against an empty category and then OUT_MAX requests are refilled: a counter that wrapped on underflow would refuse them early.

// File: rtl/agp_seq_pkg.sv
// Shared types for the graphics port request sequencer.
// Assumes status code values are fixed by the arbiter protocol.
package agp_seq_pkg;
    typedef enum logic [2:0] {
        ST_RD_LO = 3'b000,
        ST_RD_HI = 3'b001,
        ST_WR_LO = 3'b010,
        ST_WR_HI = 3'b011,
        ST_RSV4  = 3'b100,
        ST_RSV5  = 3'b101,
        ST_RSV6  = 3'b110,
        ST_START = 3'b111
    } agp_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_PARK
    } pipe_phase_e;

    localparam int NUM_CAT = 4;
    localparam int CAT_W   = 2;

    typedef struct packed {
        logic               start;
        logic [NUM_CAT-1:0] ret;
        logic               rsvd;
    } status_dec_t;
endpackage

// File: rtl/agp_status_decode.sv
// Decodes the arbiter status code into start, per-category return and
// reserved flags. Assumes the code is meaningful only while grant is low.
module agp_status_decode
    import agp_seq_pkg::*;
(
    input  logic        gnt_n,
    input  logic [2:0]  st_code,
    output status_dec_t dec
);
    // Qualify the code with grant and split it into flags.
    always_comb begin
        dec = '0;
        if (!gnt_n) begin
            unique case (agp_status_e'(st_code))
                ST_START:                     dec.start = 1'b1;
                ST_RD_LO, ST_RD_HI,
                ST_WR_LO, ST_WR_HI:           dec.ret[st_code[1:0]] = 1'b1;
                default:                      dec.rsvd = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/agp_pipe_issue.sv
// Issue phase machine: presents one request address per clock with the
// strobe low, parks the strobe high for one cycle, then releases it.
// Assumes cat_full reflects the category of the offered request.
module agp_pipe_issue
    import agp_seq_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            req_valid,
    input  logic [AD_W-1:0] req_addr,
    input  logic            cat_full,
    output logic            req_ready,
    output logic            pipe_n,
    output logic            pipe_oe,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe
);
    pipe_phase_e phase;

    // Accept a request only with permission, room, and not while parking.
    assign req_ready = start && req_valid && !cat_full && (phase != PH_PARK);

    // Step the issue phase and register the bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pipe_n  <= 1'b1;
            pipe_oe <= 1'b0;
            ad_oe   <= 1'b0;
            ad_out  <= '0;
        end else if (req_ready) begin
            phase   <= PH_ISSUE;
            pipe_n  <= 1'b0;
            pipe_oe <= 1'b1;
            ad_oe   <= 1'b1;
            ad_out  <= req_addr;
        end else if (phase == PH_ISSUE) begin
            phase   <= PH_PARK;
            pipe_n  <= 1'b1;
            ad_oe   <= 1'b0;
        end else if (phase == PH_PARK) begin
            phase   <= PH_IDLE;
            pipe_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/agp_outstanding.sv
// Outstanding-request counter for one category. Saturates at OUT_MAX
// (the issuer never increments when full) and never goes below zero.
module agp_outstanding #(
    parameter int OUT_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic under
);
    localparam int CNT_W = $clog2(OUT_MAX + 1);

    logic [CNT_W-1:0] cnt;

    assign full  = (cnt == CNT_W'(OUT_MAX));
    assign under = dec && (cnt == '0);

    // Count issued requests up and matching returns down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && !(dec && cnt != '0)) begin
            cnt <= cnt + 1'b1;
        end else if (!inc && dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/agp_rbf_flow.sv
// Read-buffer-full flag: asserted low when fewer than XFER_WORDS entries
// remain free in the low-priority read buffer. Tristated during reset.
module agp_rbf_flow #(
    parameter int BUF_W      = 4,
    parameter int XFER_WORDS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUF_W-1:0] lo_free,
    output logic             rbf_n,
    output logic             rbf_oe
);
    // Register the flag and enable it once out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbf_n  <= 1'b1;
            rbf_oe <= 1'b0;
        end else begin
            rbf_oe <= 1'b1;
            rbf_n  <= !(lo_free < BUF_W'(XFER_WORDS));
        end
    end
endmodule

// File: rtl/agp_req_seq.sv
// Graphics port master sequencer top: decodes status, issues pipelined
// requests, tracks outstanding requests per category {write,hipri},
// drives read-buffer-full and reports events and sticky errors.
module agp_req_seq
    import agp_seq_pkg::*;
#(
    parameter int AD_W       = 32,
    parameter int OUT_MAX    = 7,
    parameter int BUF_W      = 4,
    parameter int XFER_WORDS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_hipri,
    input  logic [AD_W-1:0]    req_addr,
    input  logic               gnt_n,
    input  logic [2:0]         st_code,
    input  logic [BUF_W-1:0]   lo_free,
    output logic               pipe_n,
    output logic               pipe_oe,
    output logic [AD_W-1:0]    ad_out,
    output logic               ad_oe,
    output logic               rbf_n,
    output logic               rbf_oe,
    output logic [NUM_CAT-1:0] ret_evt,
    output logic               cnt_err,
    output logic               proto_err
);
    status_dec_t        dec;
    logic [CAT_W-1:0]   req_cat;
    logic [NUM_CAT-1:0] cat_full;
    logic [NUM_CAT-1:0] cat_under;

    assign req_cat = {req_write, req_hipri};

    agp_status_decode u_dec (
        .gnt_n   (gnt_n),
        .st_code (st_code),
        .dec     (dec)
    );

    agp_pipe_issue #(.AD_W(AD_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dec.start),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .cat_full  (cat_full[req_cat]),
        .req_ready (req_ready),
        .pipe_n    (pipe_n),
        .pipe_oe   (pipe_oe),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe)
    );

    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
        agp_outstanding #(.OUT_MAX(OUT_MAX)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (req_ready && (req_cat == CAT_W'(c))),
            .dec   (dec.ret[c]),
            .full  (cat_full[c]),
            .under (cat_under[c])
        );
    end

    agp_rbf_flow #(.BUF_W(BUF_W), .XFER_WORDS(XFER_WORDS)) u_rbf (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_free (lo_free),
        .rbf_n   (rbf_n),
        .rbf_oe  (rbf_oe)
    );

    // Register return events and accumulate sticky error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_evt   <= '0;
            cnt_err   <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            ret_evt   <= dec.ret;
            cnt_err   <= cnt_err | (|cat_under);
            proto_err <= proto_err | dec.rsvd | (dec.ret[0] && !rbf_n);
        end
    end
endmodule

// File: rtl/agp_req_seq_chk.sv
// Protocol checker for agp_req_seq, attached with bind below.
module agp_req_seq_chk #(
    parameter int BUF_W      = 4,
    parameter int XFER_WORDS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             gnt_n,
    input logic [2:0]       st_code,
    input logic [BUF_W-1:0] lo_free,
    input logic             pipe_n,
    input logic             pipe_oe,
    input logic             ad_oe,
    input logic             rbf_n,
    input logic             rbf_oe,
    input logic [3:0]       ret_evt,
    input logic             cnt_err,
    input logic             proto_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!pipe_oe && !ad_oe && !rbf_oe)); // R1
    AST_NO_GRANT_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n) gnt_n |=> (ret_evt == 4'b0)); // R2
    AST_READY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (!gnt_n && st_code == 3'b111)); // R3
    AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) !pipe_n |-> (pipe_oe && ad_oe)); // R3
    AST_PARK_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(pipe_oe) |-> ($past(pipe_n) && $past(pipe_oe))); // R4
    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ret_evt)); // R5
    AST_CNT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cnt_err |=> cnt_err); // R7
    AST_RBF_LOW_ON_SHORT: assert property (@(posedge clk) disable iff (!rst_n) (lo_free < BUF_W'(XFER_WORDS)) |=> !rbf_n); // R8
    AST_HI_READ_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!gnt_n && st_code == 3'b001) |=> ret_evt[1]); // R9
    AST_LO_READ_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n) (!gnt_n && st_code == 3'b000 && !rbf_n) |=> proto_err); // R10
    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (!gnt_n && st_code[2] && st_code != 3'b111) |=> (proto_err && ret_evt == 4'b0)); // R11
    AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> proto_err); // R11
endmodule

bind agp_req_seq agp_req_seq_chk #(.BUF_W(BUF_W), .XFER_WORDS(XFER_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .gnt_n     (gnt_n),
    .st_code   (st_code),
    .lo_free   (lo_free),
    .pipe_n    (pipe_n),
    .pipe_oe   (pipe_oe),
    .ad_oe     (ad_oe),
    .rbf_n     (rbf_n),
    .rbf_oe    (rbf_oe),
    .ret_evt   (ret_evt),
    .cnt_err   (cnt_err),
    .proto_err (proto_err)
);

// File: tb/tb_agp_req_seq.sv
module tb_agp_req_seq;
    localparam int AD_W = 32;
    localparam int OUT_MAX = 7;
    localparam int BUF_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic req_hipri = 1'b0;
    logic [AD_W-1:0] req_addr = '0;
    logic gnt_n = 1'b1;
    logic [2:0] st_code = 3'b000;
    logic [BUF_W-1:0] lo_free = 4'd15;
    logic pipe_n, pipe_oe, ad_oe, rbf_n, rbf_oe, cnt_err, proto_err;
    logic [AD_W-1:0] ad_out;
    logic [3:0] ret_evt;

    int checks = 0;
    int failures = 0;
    logic [AD_W-1:0] exp_q[$];

    always #5 clk = ~clk;

    agp_req_seq #(.AD_W(AD_W), .OUT_MAX(OUT_MAX), .BUF_W(BUF_W), .XFER_WORDS(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_hipri(req_hipri), .req_addr(req_addr),
        .gnt_n(gnt_n), .st_code(st_code), .lo_free(lo_free),
        .pipe_n(pipe_n), .pipe_oe(pipe_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .rbf_n(rbf_n), .rbf_oe(rbf_oe), .ret_evt(ret_evt),
        .cnt_err(cnt_err), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected addresses as requests appear on the bus (R3).
    always @(negedge clk) begin
        if (rst_n && pipe_oe && !pipe_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected issue", {32'b0, ad_out}, 64'h0);
            end else begin
                logic [AD_W-1:0] e;
                e = exp_q.pop_front();
                chk(ad_out == e && ad_oe, "R3 issued address", {32'b0, ad_out}, {32'b0, e});
            end
        end
    end

    // Driver: offers n requests under start permission; expects n_ok accepted.
    task automatic issue_burst(input int n, input int n_ok, input bit w, input bit hi,
                               input logic [AD_W-1:0] base, input bit park_chk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_write = w; req_hipri = hi; req_addr = base + AD_W'(i * 4);
            req_valid = 1'b1; gnt_n = 1'b0; st_code = 3'b111;
            #1;
            if (req_ready) exp_q.push_back(req_addr);
            chk(req_ready == (i < n_ok), "R6 ready per category limit", {63'b0, req_ready}, {63'b0, (i < n_ok)});
        end
        @(negedge clk);
        req_valid = 1'b0; gnt_n = 1'b1;
        @(negedge clk);
        if (park_chk) chk(pipe_n && pipe_oe && !ad_oe, "R4 park cycle", {61'b0, pipe_n, pipe_oe, ad_oe}, 64'h6);
        @(negedge clk);
        if (park_chk) chk(!pipe_oe, "R4 release", {63'b0, pipe_oe}, 64'h0);
    endtask

    // Presents one status code for one cycle, leaves grant off after.
    task automatic send_status(input logic [2:0] code, input bit granted);
        @(negedge clk);
        req_valid = 1'b0; gnt_n = !granted; st_code = code;
        @(negedge clk);
        gnt_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; gnt_n = 1'b1; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!pipe_oe && !ad_oe && !rbf_oe, "R1 outputs tristated in reset", {61'b0, pipe_oe, ad_oe, rbf_oe}, 64'h0);
        chk(!cnt_err && !proto_err, "R1 errors cleared", {62'b0, cnt_err, proto_err}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rbf_oe && rbf_n, "R1 flag enabled after reset", {62'b0, rbf_oe, rbf_n}, 64'h3);
    endtask

    initial begin
        do_reset();

        // R2: start code without grant
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hDEAD0000; gnt_n = 1'b1; st_code = 3'b111;
        #1 chk(!req_ready, "R2 no ready without grant", {63'b0, req_ready}, 64'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!pipe_oe && pipe_n, "R2 no issue without grant", {62'b0, pipe_oe, pipe_n}, 64'h1);
        send_status(3'b001, 1'b0);
        chk(ret_evt == 4'b0 && !cnt_err, "R2 return ignored without grant", {59'b0, cnt_err, ret_evt}, 64'h0);

        // R3/R4: burst of low reads, then one of each other category
        issue_burst(3, 3, 1'b0, 1'b0, 32'h1000_0000, 1'b1);
        issue_burst(1, 1, 1'b0, 1'b1, 32'h2000_0000, 1'b1);
        issue_burst(1, 1, 1'b1, 1'b0, 32'h3000_0000, 1'b1);
        issue_burst(1, 1, 1'b1, 1'b1, 32'h4000_0000, 1'b1);

        // R5: each return code
        send_status(3'b000, 1'b1);
        chk(ret_evt == 4'b0001, "R5 low read return", {60'b0, ret_evt}, 64'h1);
        send_status(3'b001, 1'b1);
        chk(ret_evt == 4'b0010, "R5 high read return", {60'b0, ret_evt}, 64'h2);
        send_status(3'b010, 1'b1);
        chk(ret_evt == 4'b0100, "R5 low write data", {60'b0, ret_evt}, 64'h4);
        send_status(3'b011, 1'b1);
        chk(ret_evt == 4'b1000, "R5 high write data", {60'b0, ret_evt}, 64'h8);
        @(negedge clk);
        chk(ret_evt == 4'b0 && !cnt_err && !proto_err, "R5 single pulse no error", {58'b0, cnt_err, proto_err, ret_evt}, 64'h0);

        // R8: buffer short
        issue_burst(1, 1, 1'b0, 1'b1, 32'h2000_0100, 1'b0);
        lo_free = 4'd1;
        @(negedge clk);
        chk(!rbf_n, "R8 flag asserted when space short", {63'b0, rbf_n}, 64'h0);
        // R9: high read return not blocked
        send_status(3'b001, 1'b1);
        chk(ret_evt == 4'b0010 && !proto_err, "R9 high read passes flag", {59'b0, proto_err, ret_evt}, 64'h2);
        // R10: low read return against flag
        send_status(3'b000, 1'b1);
        chk(proto_err, "R10 low read while full", {63'b0, proto_err}, 64'h1);
        lo_free = 4'd2;
        @(negedge clk);
        @(negedge clk);
        chk(rbf_n, "R8 flag released when space freed", {63'b0, rbf_n}, 64'h1);

        // R7: return on empty high-write category
        chk(!cnt_err, "R7 no count error yet", {63'b0, cnt_err}, 64'h0);
        send_status(3'b011, 1'b1);
        chk(cnt_err, "R7 return with nothing outstanding", {63'b0, cnt_err}, 64'h1);
        // R6/R7: counter did not wrap; fills to OUT_MAX then refuses
        issue_burst(OUT_MAX + 1, OUT_MAX, 1'b1, 1'b1, 32'h5000_0000, 1'b0);
        repeat (2) @(negedge clk);
        chk(cnt_err, "R7 count error sticky", {63'b0, cnt_err}, 64'h1);

        // R11: reserved codes
        do_reset();
        send_status(3'b100, 1'b1);
        chk(ret_evt == 4'b0 && proto_err, "R11 reserved 100", {59'b0, proto_err, ret_evt}, 64'h10);
        send_status(3'b101, 1'b1);
        chk(ret_evt == 4'b0 && !pipe_oe, "R11 reserved 101", {59'b0, pipe_oe, ret_evt}, 64'h0);
        send_status(3'b110, 1'b1);
        chk(ret_evt == 4'b0 && proto_err && !cnt_err, "R11 reserved 110", {58'b0, cnt_err, proto_err, ret_evt}, 64'h10);

        chk(exp_q.size() == 0, "R3 all expected requests issued", 64'(exp_q.size()), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule